// File: doc/BRIEF.md
# Socket Fault Latch and Alert Responder

This block gathers the fault signals of a two-socket card power switch: an overcurrent flag for each of the four switched outputs (logic supply and programming supply, per socket), a supply undervoltage flag and an over-temperature flag. All of them arrive already digitised. An overcurrent flag counts only after it has stayed high for a programmable number of consecutive clock cycles. A qualified fault drives an active-low open-drain alert line at once and keeps it low after the fault has gone. The first fault pattern is frozen in a status byte.

The host can service the block through its serial slave in two separate ways. An alert-pointer read sends the device's own address bit by bit, with wired-AND arbitration against other devices that answer the same read. Winning that read releases the alert. A channel status read takes the status byte and clears it. Each read touches only its own state. A fault that is still present after either read latches again.

The arbitration path is a small state machine with three states. ARB_IDLE waits for a pointer read. The ptr_start transition leads to ARB_SEND, which shifts out the response MSB first. The lost-bit transition from ARB_SEND returns to ARB_IDLE without a win. After the eighth bit the last-bit transition leads to ARB_WIN, which clears the alert. The return transition from ARB_WIN goes back to ARB_IDLE one cycle later.

Top module: `fault_alert_ctrl`

## Requirements
- R1: After reset, alert_n is 1, status_byte is 0x00 and sda_pull is 0.
- R2: An overcurrent input latches a fault only after it has been high on QUAL_CYC consecutive rising clock edges. The alert falls one edge after that. A drop for even one cycle restarts the count, so shorter pulses have no effect.
- R3: An undervoltage input, or a thermal input while standby is 0, latches a catastrophic fault on the next rising edge. The alert falls at that edge and status bit 7 is set.
- R4: While standby is 1, the thermal input is ignored: it touches neither alert_n nor status_byte.
- R5: Status bit 7 is the catastrophic fault. Bits 6, 5, 4 and 3 are overcurrent on oc_raw[0] (socket A logic), oc_raw[1] (socket A programming), oc_raw[2] (socket B logic) and oc_raw[3] (socket B programming). Bits 2..0 read 0. Only the first fault event is captured: later faults do not change a non-zero status byte.
- R6: Once low, alert_n stays low after every fault input has returned to 0, until a won pointer read.
- R7: While mask is 1, no fault sets the alert. Faults are still captured in status_byte.
- R8: A ptr_start pulse starts the pointer response {1,0,1,0,0,addr_sel,0,0}, sent MSB first. sda_pull is 1 while the current bit is 0. Each bit_strobe advances one bit. After eight bits without a loss, alert_n returns to 1 on the second rising edge after the last strobe. status_byte is unchanged.
- R9: If the block sends a 1 and sda_in reads 0 at a bit_strobe, the block has lost. It holds sda_pull at 0 for the remaining bits and alert_n stays low.
- R10: A stat_rd pulse clears status_byte to 0x00 on the next rising edge and leaves alert_n as it was. A fault that is still present is captured again one edge later.
- R11: If a fault persists when a pointer read is won, alert_n goes high for exactly one cycle and then falls again. status_byte is not reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| oc_raw | input | 4 | Raw overcurrent flags: A logic, A programming, B logic, B programming |
| uvlo | input | 1 | Supply undervoltage flag |
| thermal | input | 1 | Over-temperature flag |
| standby | input | 1 | All switches grounded or high impedance; disables thermal detection |
| mask | input | 1 | Fault alert mask |
| addr_sel | input | 1 | Address select strap |
| ptr_start | input | 1 | Pulse: an alert-pointer read has been addressed |
| bit_strobe | input | 1 | Pulse: sample the data line for the current response bit |
| sda_in | input | 1 | Data line level seen on the bus |
| stat_rd | input | 1 | Pulse: the status byte has been read |
| status_byte | output | 8 | Captured fault status |
| sda_pull | output | 1 | Pull the data line low |
| alert_n | output | 1 | Open-drain alert level, active low |

## Verification
If the persistence counter is off by one, the alert falls one cycle early or late relative to QUAL_CYC. The bench checks the exact edge on both sides. A wrong capture or clear state shows on status_byte on the edge after the triggering fault or read, for example a reload of later faults or a clear caused by the wrong read type. A fault in the arbitration machine shows on sda_pull within the bit where it goes wrong: a wrong response bit, or driving after a loss. It also shows on alert_n on the second edge after the last strobe.

// File: rtl/fault_pkg.sv
package fault_pkg;
    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_SEND = 2'd1,
        ARB_WIN  = 2'd2
    } arb_state_t;

    localparam int NUM_OC      = 4;
    localparam int RESP_BITS   = 8;
    localparam int CAP_BITS    = NUM_OC + 1;
endpackage

// File: rtl/oc_qualifier.sv
module oc_qualifier #(
    parameter int QUAL_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic qual
);
    localparam int CW = $clog2(QUAL_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(QUAL_CYC);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!raw)
            cnt <= '0;
        else if (cnt < LIMIT)
            cnt <= cnt + 1'b1;
    end

    always_comb qual = raw && (cnt == LIMIT);

    // a drop restarts the persistence count
    assert_qual_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !raw |=> !qual);
endmodule

// File: rtl/fault_capture.sv
module fault_capture
    import fault_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_OC-1:0] oc_q,
    input  logic              uvlo,
    input  logic              thermal,
    input  logic              standby,
    input  logic              clr,
    output logic [CAP_BITS-1:0] fault_q,
    output logic              event_any
);
    logic cat;
    logic [CAP_BITS-1:0] now;

    always_comb begin
        cat       = uvlo || (thermal && !standby);
        now       = {cat, oc_q[0], oc_q[1], oc_q[2], oc_q[3]};
        event_any = |now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            fault_q <= '0;
        else if (clr)
            fault_q <= '0;
        else if (fault_q == '0)
            fault_q <= now;
    end

    // first event only: a non-zero capture holds until a status read
    assert_first_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q != '0 && !clr) |=> $stable(fault_q));

    assert_stat_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> fault_q == '0);
endmodule

// File: rtl/alert_arbiter.sv
module alert_arbiter
    import fault_pkg::*;
#(
    parameter logic [4:0] ADDR_BASE = 5'b10100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic event_any,
    input  logic mask,
    input  logic addr_sel,
    input  logic ptr_start,
    input  logic bit_strobe,
    input  logic sda_in,
    output logic alert_q,
    output logic sda_pull
);
    localparam int BW = $clog2(RESP_BITS);

    arb_state_t state, state_nx;
    logic [RESP_BITS-1:0] shreg;
    logic [BW-1:0]        bitcnt;
    logic                 lost_bit;
    logic                 last_bit;

    always_comb begin
        lost_bit = bit_strobe && shreg[RESP_BITS-1] && !sda_in;
        last_bit = bit_strobe && !lost_bit && (bitcnt == BW'(RESP_BITS - 1));
        state_nx = state;
        unique case (state)
            ARB_IDLE: if (ptr_start) state_nx = ARB_SEND;
            ARB_SEND: begin
                if (lost_bit)      state_nx = ARB_IDLE;
                else if (last_bit) state_nx = ARB_WIN;
            end
            ARB_WIN:  state_nx = ARB_IDLE;
            default:  state_nx = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ARB_IDLE;
            shreg  <= '0;
            bitcnt <= '0;
        end else begin
            state <= state_nx;
            if (state == ARB_IDLE && ptr_start) begin
                shreg  <= {ADDR_BASE, addr_sel, 1'b0, 1'b0};
                bitcnt <= '0;
            end else if (state == ARB_SEND && bit_strobe) begin
                shreg  <= {shreg[RESP_BITS-2:0], 1'b0};
                bitcnt <= bitcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            alert_q <= 1'b0;
        else if (state == ARB_WIN)
            alert_q <= 1'b0;
        else if (event_any && !mask)
            alert_q <= 1'b1;
    end

    always_comb sda_pull = (state == ARB_SEND) && !shreg[RESP_BITS-1];

    assert_win_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        state == ARB_WIN |=> !alert_q);

    assert_lose_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_SEND && lost_bit && alert_q) |=> (alert_q && !sda_pull));

    assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask && !alert_q) |=> !alert_q);
endmodule

// File: rtl/fault_alert_ctrl.sv
module fault_alert_ctrl
    import fault_pkg::*;
#(
    parameter int         QUAL_CYC  = 200,
    parameter logic [4:0] ADDR_BASE = 5'b10100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] oc_raw,
    input  logic       uvlo,
    input  logic       thermal,
    input  logic       standby,
    input  logic       mask,
    input  logic       addr_sel,
    input  logic       ptr_start,
    input  logic       bit_strobe,
    input  logic       sda_in,
    input  logic       stat_rd,
    output logic [7:0] status_byte,
    output logic       sda_pull,
    output logic       alert_n
);
    logic [NUM_OC-1:0]   oc_q;
    logic [CAP_BITS-1:0] fault_q;
    logic                event_any;
    logic                alert_q;

    for (genvar i = 0; i < NUM_OC; i++) begin : g_qual
        oc_qualifier #(.QUAL_CYC(QUAL_CYC)) u_qual (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (oc_raw[i]),
            .qual (oc_q[i])
        );
    end

    fault_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .oc_q     (oc_q),
        .uvlo     (uvlo),
        .thermal  (thermal),
        .standby  (standby),
        .clr      (stat_rd),
        .fault_q  (fault_q),
        .event_any(event_any)
    );

    alert_arbiter #(.ADDR_BASE(ADDR_BASE)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .event_any (event_any),
        .mask      (mask),
        .addr_sel  (addr_sel),
        .ptr_start (ptr_start),
        .bit_strobe(bit_strobe),
        .sda_in    (sda_in),
        .alert_q   (alert_q),
        .sda_pull  (sda_pull)
    );

    always_comb begin
        status_byte = {fault_q, 3'b000};
        alert_n     = !alert_q;
    end

    // a captured fault with the mask clear always shows on the alert line
    assert_alert_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask && !$past(mask) && $rose(fault_q != '0)) |-> !alert_n);
endmodule

// File: tb/fault_alert_ctrl_bench.sv
module fault_alert_ctrl_bench;
    localparam int QC = 200;

    logic       clk = 0;
    logic       rst_n = 0;
    logic [3:0] oc_raw = 0;
    logic       uvlo = 0, thermal = 0, standby = 0, mask = 0, addr_sel = 0;
    logic       ptr_start = 0, bit_strobe = 0, sda_in = 1, stat_rd = 0;
    logic [7:0] status_byte;
    logic       sda_pull, alert_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    fault_alert_ctrl #(.QUAL_CYC(QC)) u_fault_alert_ctrl (
        .clk(clk), .rst_n(rst_n), .oc_raw(oc_raw), .uvlo(uvlo),
        .thermal(thermal), .standby(standby), .mask(mask),
        .addr_sel(addr_sel), .ptr_start(ptr_start),
        .bit_strobe(bit_strobe), .sda_in(sda_in), .stat_rd(stat_rd),
        .status_byte(status_byte), .sda_pull(sda_pull), .alert_n(alert_n)
    );

    always #5 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        oc_raw = 0; uvlo = 0; thermal = 0; standby = 0; mask = 0;
        ptr_start = 0; bit_strobe = 0; sda_in = 1; stat_rd = 0;
        rst_n = 0;
        tick(2);
        rst_n = 1;
        tick(1);
    endtask

    // pointer read; other responder present when has_other
    task automatic ptr_read(input string req, input logic [7:0] own,
                            input logic [7:0] other, input bit has_other);
        bit lost = 0;
        ptr_start = 1; tick(1); ptr_start = 0;
        for (int i = 7; i >= 0; i--) begin
            logic bus;
            check(req, {7'd0, sda_pull}, {7'd0, !lost && !own[i]});
            bus = (lost ? 1'b1 : own[i]) & (has_other ? other[i] : 1'b1);
            if (!lost && own[i] && !bus) lost = 1;
            sda_in = bus; bit_strobe = 1;
            tick(1);
            bit_strobe = 0; sda_in = 1;
        end
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 alert", {7'd0, alert_n}, 8'd1);
        check("R1 status", status_byte, 8'h00);
        check("R1 pull", {7'd0, sda_pull}, 8'd0);
    endtask

    task automatic t_oc_qual();
        do_reset();
        oc_raw[0] = 1; tick(QC - 1); oc_raw[0] = 0; tick(1);
        oc_raw[0] = 1; tick(QC - 1);
        check("R2 short pulses", {7'd0, alert_n}, 8'd1);
        oc_raw[0] = 0; tick(2);
        oc_raw[0] = 1; tick(QC);
        check("R2 just before", {7'd0, alert_n}, 8'd1);
        tick(1);
        check("R2 qualified", {7'd0, alert_n}, 8'd0);
        check("R5 bit6", status_byte, 8'h40);
        oc_raw[0] = 0; tick(5);
        check("R6 sticky", {7'd0, alert_n}, 8'd0);
        oc_raw[2] = 1; tick(QC + 3);
        check("R5 first only", status_byte, 8'h40);
        oc_raw[2] = 0;
    endtask

    task automatic t_oc_bits();
        do_reset();
        oc_raw[3] = 1; tick(QC + 1);
        check("R5 bit3", status_byte, 8'h08);
        do_reset();
        oc_raw = 4'b0110; tick(QC + 1);
        check("R5 bits5 4", status_byte, 8'h30);
    endtask

    task automatic t_cat();
        do_reset();
        uvlo = 1; tick(1);
        check("R3 uv alert", {7'd0, alert_n}, 8'd0);
        check("R3 uv status", status_byte, 8'h80);
        do_reset();
        standby = 1; thermal = 1; tick(4);
        check("R4 alert", {7'd0, alert_n}, 8'd1);
        check("R4 status", status_byte, 8'h00);
        standby = 0; tick(1);
        check("R3 thermal", status_byte, 8'h80);
        check("R3 thermal alert", {7'd0, alert_n}, 8'd0);
    endtask

    task automatic t_mask();
        do_reset();
        mask = 1; uvlo = 1; tick(3);
        check("R7 alert", {7'd0, alert_n}, 8'd1);
        check("R7 status", status_byte, 8'h80);
    endtask

    task automatic t_ptr_win();
        do_reset();
        addr_sel = 1;
        uvlo = 1; tick(1); uvlo = 0; tick(1);
        ptr_read("R8 bit", 8'hA4, 8'h00, 0);
        check("R8 still low", {7'd0, alert_n}, 8'd0);
        tick(1);
        check("R8 cleared", {7'd0, alert_n}, 8'd1);
        check("R8 status kept", status_byte, 8'h80);
        tick(3);
        check("R8 stays clear", {7'd0, alert_n}, 8'd1);
    endtask

    task automatic t_ptr_lose();
        do_reset();
        addr_sel = 1;
        uvlo = 1; tick(1); uvlo = 0; tick(1);
        ptr_read("R9 bit", 8'hA4, 8'hA0, 1);
        tick(3);
        check("R9 alert kept", {7'd0, alert_n}, 8'd0);
        check("R9 pull", {7'd0, sda_pull}, 8'd0);
    endtask

    task automatic t_persist();
        do_reset();
        addr_sel = 0;
        uvlo = 1; tick(1);
        ptr_read("R11 bit", 8'hA0, 8'h00, 0);
        tick(1);
        check("R11 release", {7'd0, alert_n}, 8'd1);
        tick(1);
        check("R11 reassert", {7'd0, alert_n}, 8'd0);
        check("R11 no reload", status_byte, 8'h80);
        uvlo = 0;
    endtask

    task automatic t_stat();
        do_reset();
        oc_raw[1] = 1; tick(QC + 1); oc_raw[1] = 0; tick(1);
        check("R10 before", status_byte, 8'h20);
        stat_rd = 1; tick(1); stat_rd = 0;
        check("R10 cleared", status_byte, 8'h00);
        check("R10 alert kept", {7'd0, alert_n}, 8'd0);
        tick(2);
        check("R10 stays clear", status_byte, 8'h00);
        uvlo = 1; tick(1);
        check("R10 new event", status_byte, 8'h80);
        stat_rd = 1; tick(1); stat_rd = 0;
        check("R10 clear persist", status_byte, 8'h00);
        tick(1);
        check("R10 relatch", status_byte, 8'h80);
        uvlo = 0;
    endtask

    initial begin
        t_reset();
        t_oc_qual();
        t_oc_bits();
        t_cat();
        t_mask();
        t_ptr_win();
        t_ptr_lose();
        t_persist();
        t_stat();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule